// File: doc/BRIEF.md
# Two-digit packed decimal adder/subtractor

This unit performs decimal arithmetic on packed BCD bytes. Each accepted request supplies an accumulator value, a memory operand, the current carry flag and an operation code. In a single pass the unit adds or subtracts, applies the decimal correction to each digit, and returns the corrected accumulator and the new carry flag. Results are registered and appear one clock cycle after the request.

The operation code uses the same layout as the binary arithmetic group. The low three bits select the kind: `100` is add and `111` is subtract. Bit 7 clear selects the variant that consumes the incoming flag. Bit 3 marks the immediate form, which only changes where the operand comes from, so the unit ignores it. Subtraction always computes accumulator minus operand. On the subtract side a flag of 1 means no borrow, so a borrow-in is taken when the incoming flag is 0. Operand digits above 9 fall outside what the unit is specified for.

The digit count is a parameter (default two digits, one byte). Decimal carries ripple through one correction slice per digit.

Top module: `bcd_alu`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `d_o` and `df_o` are all 0.
- R2: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high, and in no other cycle.
- R3: An op with low bits `100` and bit 7 = 1 (e.g. 0xF4) returns `d_o` = (D + M) mod 100 in BCD and `df_o` = 1 exactly when D + M ≥ 100.
- R4: An op with low bits `100` and bit 7 = 0 (e.g. 0x74) adds `df_i` as a carry-in: `d_o` = (D + M + DF) mod 100, `df_o` = 1 when the sum is ≥ 100.
- R5: An op with low bits `111` and bit 7 = 1 (e.g. 0xF7) returns D − M, plus 100 if negative, and `df_o` = 1 exactly when D ≥ M (1 means no borrow).
- R6: An op with low bits `111` and bit 7 = 0 (e.g. 0x77) returns D − M − (1 − DF), plus 100 if negative, and `df_o` = 1 exactly when that difference is ≥ 0.
- R7: Bit 3 of `op_i` has no effect: 0xFC, 0x7C, 0xFF and 0x7F give the same results as 0xF4, 0x74, 0xF7 and 0x77.
- R8: Any op whose low three bits are neither `100` nor `111` returns `d_o` = `d_i` and `df_o` = `df_i` unchanged.
- R9: `d_o` and `df_o` keep their values in cycles after a cycle with `valid_i` low.
- R10: When D and M are valid BCD, every digit of `d_o` is valid BCD (0 to 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 8 | Operation code |
| opnd_i | input | 4*NUM_DIGITS | Memory operand, packed BCD |
| d_i | input | 4*NUM_DIGITS | Accumulator in, packed BCD |
| df_i | input | 1 | Carry flag in |
| valid_o | output | 1 | Result strobe |
| d_o | output | 4*NUM_DIGITS | Corrected accumulator |
| df_o | output | 1 | Carry flag out (1 = carry for add, no borrow for subtract) |

## Verification
The difficult cases are sums and differences where a correction in the low digit causes a carry or borrow into the high digit, and that in turn changes the outgoing flag. Examples are 99 + 01 with a carry-in, or 00 − 00 with a borrow-in. These occur only for particular operand pairs. The stimulus therefore sweeps every valid accumulator and operand pair, with both flag values, for all four operations. Each result is compared with a plain integer model of the decimal sum or difference.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  typedef enum logic [1:0] {
    KIND_PASS = 2'd0,
    KIND_ADD  = 2'd1,
    KIND_SUB  = 2'd2
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     use_flag;
  } op_dec_t;

  localparam logic [2:0] SEL_ADD = 3'b100;
  localparam logic [2:0] SEL_SUB = 3'b111;

endpackage

// File: rtl/bcd_op_decode.sv
module bcd_op_decode
  import bcd_alu_pkg::*;
(
  input  logic [7:0] op_i,
  output op_dec_t    dec_o
);

  // bit 3 (immediate form) only selects the operand source upstream
  always_comb begin
    dec_o.use_flag = ~op_i[7];
    unique case (op_i[2:0])
      SEL_ADD: dec_o.kind = KIND_ADD;
      SEL_SUB: dec_o.kind = KIND_SUB;
      default: dec_o.kind = KIND_PASS;
    endcase
  end

endmodule

// File: rtl/bcd_digit.sv
module bcd_digit (
  input  logic       sub_i,
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cy_i,
  output logic [3:0] r_o,
  output logic       cy_o
);

  logic [4:0] sum;
  logic [4:0] diff;

  always_comb begin
    sum  = {1'b0, a_i} + {1'b0, b_i} + {4'd0, cy_i};
    diff = {1'b0, a_i} - {1'b0, b_i} - {4'd0, cy_i};
    if (sub_i) begin
      // negative difference: wrap to the decimal digit by removing 6
      cy_o = diff[4];
      r_o  = diff[4] ? diff[3:0] - 4'd6 : diff[3:0];
    end else begin
      cy_o = (sum > 5'd9);
      r_o  = (sum > 5'd9) ? sum[3:0] + 4'd6 : sum[3:0];
    end
  end

endmodule

// File: rtl/bcd_chain.sv
module bcd_chain #(
  parameter int NUM_DIGITS = 2,
  localparam int W = 4 * NUM_DIGITS
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] r_o,
  output logic         cy_o
);

  logic [NUM_DIGITS:0] cy;

  assign cy[0] = cy_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    bcd_digit i_dig (
      .sub_i (sub_i),
      .a_i   (a_i[4*g +: 4]),
      .b_i   (b_i[4*g +: 4]),
      .cy_i  (cy[g]),
      .r_o   (r_o[4*g +: 4]),
      .cy_o  (cy[g+1])
    );
  end

  assign cy_o = cy[NUM_DIGITS];

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  localparam int W = 4 * NUM_DIGITS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [7:0]   op_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] d_i,
  input  logic         df_i,
  output logic         valid_o,
  output logic [W-1:0] d_o,
  output logic         df_o
);

  op_dec_t      dec;
  logic         is_sub;
  logic         cy_in;
  logic [W-1:0] res;
  logic         cy_out;
  logic [W-1:0] d_nxt;
  logic         df_nxt;

  bcd_op_decode i_dec (
    .op_i  (op_i),
    .dec_o (dec)
  );

  assign is_sub = (dec.kind == KIND_SUB);
  // subtract borrow-in is the inverse of the flag
  assign cy_in  = dec.use_flag & (is_sub ? ~df_i : df_i);

  bcd_chain #(.NUM_DIGITS(NUM_DIGITS)) i_chain (
    .sub_i (is_sub),
    .a_i   (d_i),
    .b_i   (opnd_i),
    .cy_i  (cy_in),
    .r_o   (res),
    .cy_o  (cy_out)
  );

  always_comb begin
    unique case (dec.kind)
      KIND_ADD: begin d_nxt = res; df_nxt = cy_out;  end
      KIND_SUB: begin d_nxt = res; df_nxt = ~cy_out; end
      default:  begin d_nxt = d_i; df_nxt = df_i;    end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      d_o     <= '0;
      df_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        d_o  <= d_nxt;
        df_o <= df_nxt;
      end
    end
  end

endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk #(
  parameter int NUM_DIGITS = 2,
  localparam int W = 4 * NUM_DIGITS
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [7:0]   op_i,
  input logic [W-1:0] opnd_i,
  input logic [W-1:0] d_i,
  input logic         df_i,
  input logic         valid_o,
  input logic [W-1:0] d_o,
  input logic         df_o
);

  function automatic logic all_bcd(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NUM_DIGITS; k++) if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic arith_op;
  logic pass_op;
  logic sub_plain;
  assign arith_op  = (op_i[2:0] == 3'b100) || (op_i[2:0] == 3'b111);
  assign pass_op   = !arith_op;
  assign sub_plain = (op_i[2:0] == 3'b111) && op_i[7];

  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!valid_o && d_o == '0 && !df_o)
        else $error("reset state not clear");
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("missing result strobe");

  p_valid_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("spurious result strobe");

  p_self_sub_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_plain && d_i == opnd_i) |=> (d_o == '0 && df_o))
    else $error("D minus D not zero without borrow");

  p_pass_through_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pass_op) |=> (d_o == $past(d_i) && df_o == $past(df_i)))
    else $error("non-arithmetic op altered state");

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(d_o) && $stable(df_o)))
    else $error("result changed without request");

  p_digits_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && all_bcd(d_i) && all_bcd(opnd_i)) |=> all_bcd(d_o))
    else $error("non-decimal result digit");

endmodule

bind bcd_alu bcd_alu_chk #(.NUM_DIGITS(NUM_DIGITS)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .opnd_i  (opnd_i),
  .d_i     (d_i),
  .df_i    (df_i),
  .valid_o (valid_o),
  .d_o     (d_o),
  .df_o    (df_o)
);

// File: tb/test_bcd_alu.sv
`timescale 1ns/1ps
module test_bcd_alu;

  localparam int W = 8;

  typedef struct {
    logic [7:0] d;
    logic       df;
    string      tag;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [7:0]   op_i = '0;
  logic [W-1:0] opnd_i = '0;
  logic [W-1:0] d_i = '0;
  logic         df_i = 1'b0;
  logic         valid_o;
  logic [W-1:0] d_o;
  logic         df_o;

  int   errors = 0;
  int   checks = 0;
  bit   done   = 1'b0;
  exp_t sb[$];

  always #2 clk_i = ~clk_i;

  bcd_alu i_bcd_alu (
    .clk_i, .rst_ni, .valid_i, .op_i, .opnd_i, .d_i, .df_i,
    .valid_o, .d_o, .df_o
  );

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic exp_t model(input logic [7:0] op, input int dv,
                                 input int mv, input logic df, input string tag);
    exp_t e;
    int   s;
    int   c;
    e.tag = tag;
    c = (!op[7]) ? 1 : 0;
    if (op[2:0] == 3'b100) begin
      s = dv + mv + (c != 0 && df ? 1 : 0);
      e.df = (s >= 100);
      e.d  = to_bcd(s % 100);
    end else if (op[2:0] == 3'b111) begin
      s = dv - mv - (c != 0 && !df ? 1 : 0);
      e.df = (s >= 0);
      e.d  = to_bcd(s < 0 ? s + 100 : s);
    end else begin
      e.df = df;
      e.d  = to_bcd(dv);
    end
    return e;
  endfunction

  task automatic issue(input logic [7:0] op, input int dv, input int mv,
                       input logic df, input string tag);
    @(posedge clk_i); #1;
    valid_i = 1'b1;
    op_i    = op;
    d_i     = to_bcd(dv);
    opnd_i  = to_bcd(mv);
    df_i    = df;
    sb.push_back(model(op, dv, mv, df, tag));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i); #1;
      valid_i = 1'b0;
      d_i     = 8'h55;
      opnd_i  = 8'h33;
      df_i    = ~df_i;
    end
  endtask

  // monitor
  logic [7:0] last_d;
  logic       last_df;
  bit         have_last = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R2 strobe without request: act=1 exp=0");
        end else begin
          e = sb.pop_front();
          if (d_o !== e.d || df_o !== e.df) begin
            errors++;
            $display("FAIL %s act d=%h df=%b exp d=%h df=%b op=%h",
                     e.tag, d_o, df_o, e.d, e.df, $past(op_i));
          end
        end
        last_d = d_o; last_df = df_o; have_last = 1'b1;
      end else if (have_last) begin
        checks++;
        if (d_o !== last_d || df_o !== last_df) begin
          errors++;
          $display("FAIL R9 hold act d=%h df=%b exp d=%h df=%b",
                   d_o, df_o, last_d, last_df);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0 || d_o !== 8'h00 || df_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset act v=%b d=%h df=%b exp v=0 d=00 df=0",
               valid_o, d_o, df_o);
    end
    @(posedge clk_i); #1 rst_ni = 1'b1;

    // corner cases first
    issue(8'h74, 99, 0, 1'b1, "R4");
    issue(8'hF4, 99, 1, 1'b0, "R3");
    issue(8'h77, 0, 0, 1'b0, "R6");
    issue(8'hF7, 10, 1, 1'b1, "R5");
    idle(3);
    // R8: non-arithmetic codes leave D and DF alone
    issue(8'hF0, 42, 17, 1'b1, "R8");
    issue(8'h71, 9, 90, 1'b0, "R8");
    issue(8'h00, 73, 5, 1'b1, "R8");
    idle(2);
    // R7: immediate forms
    for (int i = 0; i < 100; i += 7) begin
      issue(8'hFC, i, 99 - i, 1'b1, "R7");
      issue(8'h7C, i, 99 - i, 1'b1, "R7");
      issue(8'hFF, i, (i * 3) % 100, 1'b0, "R7");
      issue(8'h7F, (i * 3) % 100, i, 1'b0, "R7");
    end
    idle(4);
    // exhaustive sweep R3 R4 R5 R6 (R10 via assertion)
    for (int oi = 0; oi < 4; oi++) begin
      logic [7:0] op;
      string      tg;
      case (oi)
        0: begin op = 8'hF4; tg = "R3"; end
        1: begin op = 8'h74; tg = "R4"; end
        2: begin op = 8'hF7; tg = "R5"; end
        default: begin op = 8'h77; tg = "R6"; end
      endcase
      for (int c = 0; c < 2; c++)
        for (int dv = 0; dv < 100; dv++)
          for (int mv = 0; mv < 100; mv++)
            issue(op, dv, mv, c[0], tg);
      idle(1);
    end
    idle(3);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 results missing act=%0d exp=0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule